// File: doc/BRIEF.md
# Configurable I/O Port Controller

This block is one general-purpose I/O port of up to eight pins. A microcontroller sets it up over a simple register bus. Four registers are mapped on this bus: a mode register, a direction register, a drive register and a data-out register. A fifth offset reads the pad levels after a synchronising flop chain. Bit n of every register belongs to pin n. For each pin the block picks the value to drive: either the data-out bit or one bit of an external address bus. It enables the pad driver when the direction bit is set or when an external logic-array output-enable term for that pin is active. It then applies either open-drain driving or a slew-rate choice, as fixed per pin at build time.

The register bus has no stall. A write is taken on the rising clock edge while the write strobe is high. A read returns the addressed register in the same cycle, with no handshake. The pad-side signals are plain per-pin levels. Parameters give a port variant without a mode register and a narrow variant with only a few active pins. Their missing bits read as zero and cannot be written.

Top module: `cfg_io_port`

## Requirements
- R1: After reset every register reads 00h, every pin is an input (pad_oe low while no product term is active), and pad_fast is low.
- R2: Offsets 0x0 (mode), 0x2 (direction), 0x4 (drive) and 0x6 (data-out) are written on the rising clock edge while reg_wr is high. They read back combinationally on reg_rdata. Unmapped offsets read 00h.
- R3: A mode bit of 0 drives the pin from its data-out bit. A mode bit of 1 drives it from the same-index bit of mcu_addr.
- R4: On a push-pull pin, pad_oe is the OR of its direction bit (1 = output) and its pt_oe bit. Direction 07h with no pt_oe active gives pad_oe 07h.
- R5: On a pin marked in OD_MASK with drive bit 1, pad_out is 0. pad_oe is high only when the pin is enabled and the selected value is 0, so a 1 is released.
- R6: On a pin not marked in OD_MASK, the drive bit drives pad_fast (1 = fast slew, 0 = slow). pad_fast is always 0 on OD_MASK pins.
- R7: Offset 0x8 reads pad_in through a two-flop synchroniser. A pad change therefore appears after two rising clock edges and not before.
- R8: With HAS_CTRL = 0 the mode register reads 00h and ignores writes, and every pin drives from its data-out bit.
- R9: With ACTIVE_PINS below 8, register bits of inactive pins read 0 and ignore writes. The pad_out, pad_oe and pad_fast bits of those pins stay 0 whatever pt_oe holds.
- R10: With reg_wr low, no register changes, whatever reg_addr and reg_wdata hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Combinational read data |
| mcu_addr | input | WIDTH | Address bits used in address-out mode |
| pt_oe | input | WIDTH | Per-pin output-enable product terms |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output value |
| pad_oe | output | WIDTH | Pad driver enable |
| pad_fast | output | WIDTH | Fast-slew select per pin |

## Verification
The bench builds two instances. The first uses the defaults: eight active pins, a mode register, and open-drain on pins 0 to 3. It therefore covers mode muxing, open-drain release beside push-pull pins, and slew select on pins 4 to 7. The second has ACTIVE_PINS = 2, HAS_CTRL = 0 and open-drain only on pin 0. It shows that the mode register is dropped, that the upper bits are masked on reads and writes, and that pt_oe cannot enable the inactive pads.

// File: rtl/cio_pkg.sv
`timescale 1ns/1ps
package cio_pkg;
  localparam int OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [OFS_W-1:0] OFS_DIR  = 4'h2;
  localparam logic [OFS_W-1:0] OFS_DRV  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_DOUT = 4'h6;
  localparam logic [OFS_W-1:0] OFS_DIN  = 4'h8;

  typedef struct packed {
    logic addr_mode;
    logic dir_out;
    logic drv_sel;
  } pin_cfg_t;
endpackage

// File: rtl/cio_regs.sv
`timescale 1ns/1ps
module cio_regs
  import cio_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] ACT_MASK  = '1,
  parameter logic [WIDTH-1:0] CTRL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] din_sync,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] ctrl_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] drv_q,
  output logic [WIDTH-1:0] dout_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
      dout_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_CTRL: ctrl_q <= wdata & CTRL_MASK;
        OFS_DIR:  dir_q  <= wdata & ACT_MASK;
        OFS_DRV:  drv_q  <= wdata & ACT_MASK;
        OFS_DOUT: dout_q <= wdata & ACT_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rdata = ctrl_q;
      OFS_DIR:  rdata = dir_q;
      OFS_DRV:  rdata = drv_q;
      OFS_DOUT: rdata = dout_q;
      OFS_DIN:  rdata = din_sync & ACT_MASK;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cio_sync.sv
`timescale 1ns/1ps
module cio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cio_pin.sv
`timescale 1ns/1ps
module cio_pin
  import cio_pkg::*;
#(
  parameter bit OD_CAP = 1'b0,
  parameter bit ACTIVE = 1'b1
) (
  input  pin_cfg_t cfg,
  input  logic     dout_bit,
  input  logic     addr_bit,
  input  logic     pt_bit,
  output logic     out,
  output logic     oe,
  output logic     fast
);
  if (!ACTIVE) begin : g_off
    assign out  = 1'b0;
    assign oe   = 1'b0;
    assign fast = 1'b0;
  end else begin : g_on
    logic src, en;
    assign src = cfg.addr_mode ? addr_bit : dout_bit;
    assign en  = cfg.dir_out | pt_bit;
    if (OD_CAP) begin : g_od
      // drive bit set: pull low for a 0, float for a 1
      assign out  = cfg.drv_sel ? 1'b0 : src;
      assign oe   = cfg.drv_sel ? (en & ~src) : en;
      assign fast = 1'b0;
    end else begin : g_pp
      assign out  = src;
      assign oe   = en;
      assign fast = cfg.drv_sel;
    end
  end
endmodule

// File: rtl/cfg_io_port.sv
`timescale 1ns/1ps
module cfg_io_port
  import cio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ACTIVE_PINS = 8,
  parameter bit HAS_CTRL    = 1'b1,
  parameter logic [WIDTH-1:0] OD_MASK = 'h0F,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] mcu_addr,
  input  logic [WIDTH-1:0] pt_oe,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_fast
);
  localparam logic [WIDTH-1:0] ACT_MASK  = {WIDTH{1'b1}} >> (WIDTH - ACTIVE_PINS);
  localparam logic [WIDTH-1:0] CTRL_MASK = HAS_CTRL ? ACT_MASK : '0;

  logic [WIDTH-1:0] ctrl_q, dir_q, drv_q, dout_q, din_s;

  cio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_s)
  );

  cio_regs #(.WIDTH(WIDTH), .ACT_MASK(ACT_MASK), .CTRL_MASK(CTRL_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .din_sync(din_s), .rdata(reg_rdata),
    .ctrl_q(ctrl_q), .dir_q(dir_q), .drv_q(drv_q), .dout_q(dout_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{addr_mode: ctrl_q[i], dir_out: dir_q[i], drv_sel: drv_q[i]};
    cio_pin #(.OD_CAP(OD_MASK[i]), .ACTIVE(ACT_MASK[i])) u_pin (
      .cfg(cfg), .dout_bit(dout_q[i]), .addr_bit(mcu_addr[i]), .pt_bit(pt_oe[i]),
      .out(pad_out[i]), .oe(pad_oe[i]), .fast(pad_fast[i])
    );
  end
endmodule

// File: rtl/cio_checker.sv
`timescale 1ns/1ps
module cio_checker
  import cio_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] ACT_MASK = '1,
  parameter logic [WIDTH-1:0] OD_MASK  = '0,
  parameter bit HAS_CTRL = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       reg_addr,
  input logic             reg_wr,
  input logic [WIDTH-1:0] reg_wdata,
  input logic [WIDTH-1:0] reg_rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_fast,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] drv_q
);
  AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DIR) |=> (dir_q == ($past(reg_wdata) & ACT_MASK))); // R2
  AST_DIR_ENABLES_PP: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & ~(OD_MASK & drv_q) & ~pad_oe) == '0)); // R4
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & pad_oe & OD_MASK & drv_q) == '0)); // R5
  AST_NO_FAST_ON_OD: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_fast & OD_MASK) == '0)); // R6
  AST_NO_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_CTRL && reg_addr == OFS_CTRL) |-> (reg_rdata == '0)); // R8
  AST_IDLE_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out | pad_oe | pad_fast) & ~ACT_MASK) == '0)); // R9
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(dir_q) && $stable(drv_q))); // R10
endmodule

bind cfg_io_port cio_checker #(
  .WIDTH(WIDTH), .ACT_MASK(ACT_MASK), .OD_MASK(OD_MASK), .HAS_CTRL(HAS_CTRL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_fast(pad_fast), .dir_q(dir_q), .drv_q(drv_q)
);

// File: tb/sim_cfg_io_port.sv
`timescale 1ns/1ps
module sim_cfg_io_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] a0_addr = '0, a1_addr = '0;
  logic       a0_wr = 1'b0, a1_wr = 1'b0;
  logic [7:0] a0_wd = '0, a1_wd = '0;
  logic [7:0] ma0 = '0, ma1 = '0, pt0 = '0, pt1 = '0, pin0 = '0, pin1 = '0;
  logic [7:0] rd0, rd1, po0, po1, poe0, poe1, pf0, pf1;

  cfg_io_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(a0_addr), .reg_wr(a0_wr), .reg_wdata(a0_wd),
    .reg_rdata(rd0), .mcu_addr(ma0), .pt_oe(pt0), .pad_in(pin0),
    .pad_out(po0), .pad_oe(poe0), .pad_fast(pf0)
  );

  cfg_io_port #(.ACTIVE_PINS(2), .HAS_CTRL(1'b0), .OD_MASK(8'h01)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_addr(a1_addr), .reg_wr(a1_wr), .reg_wdata(a1_wd),
    .reg_rdata(rd1), .mcu_addr(ma1), .pt_oe(pt1), .pad_in(pin1),
    .pad_out(po1), .pad_oe(poe1), .pad_fast(pf1)
  );

  int n_run = 0, n_fail = 0;
  int         q_sel[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return rd0;  1: return po0;  2: return poe0; 3: return pf0;
      4: return rd1;  5: return po1;  6: return poe1; default: return pf1;
    endcase
  endfunction

  // expected pad outputs {fast, oe, out} built from the requirements
  function automatic logic [23:0] pin_model(input logic [7:0] c, d, s, o, ma, pt, od, act,
                                           input bit hasc);
    logic [7:0] out, oe, fast;
    out = '0; oe = '0; fast = '0;
    for (int i = 0; i < 8; i++) begin
      logic src, en;
      src = (hasc && c[i]) ? ma[i] : o[i];
      en  = d[i] | pt[i];
      if (act[i]) begin
        if (od[i] && s[i]) begin
          oe[i] = en & ~src;
        end else begin
          out[i] = src; oe[i] = en; fast[i] = ~od[i] & s[i];
        end
      end
    end
    return {fast, oe, out};
  endfunction

  task automatic expect_val(input int sel, input logic [7:0] exp, input string tag);
    #1;
    q_sel.push_back(sel); q_exp.push_back(exp); q_tag.push_back(tag);
    wait (q_sel.size() == 0);
    #1;
  endtask

  // scoreboard monitor
  initial forever begin
    int sel; logic [7:0] exp, got; string tag;
    wait (q_sel.size() != 0);
    sel = q_sel[0]; exp = q_exp[0]; tag = q_tag[0];
    got = observe(sel);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d actual=%02h expected=%02h", tag, sel, got, exp);
    end
    void'(q_sel.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
  end

  task automatic wr0(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); a0_addr = a; a0_wd = d; a0_wr = 1'b1;
    @(negedge clk); a0_wr = 1'b0;
  endtask
  task automatic wr1(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); a1_addr = a; a1_wd = d; a1_wr = 1'b1;
    @(negedge clk); a1_wr = 1'b0;
  endtask

  task automatic pins0(input logic [7:0] c, d, s, o, input string tag);
    logic [23:0] m;
    m = pin_model(c, d, s, o, ma0, pt0, 8'h0F, 8'hFF, 1'b1);
    expect_val(1, m[7:0], tag);
    expect_val(2, m[15:8], tag);
    expect_val(3, m[23:16], tag);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 5; k++) begin
      a0_addr = 4'(2 * k);
      expect_val(0, 8'h00, "R1 reset read");
    end
    expect_val(2, 8'h00, "R1 reset oe");
    expect_val(3, 8'h00, "R1 reset fast");
    // R2 / R4: direction 07h example
    wr0(4'h2, 8'h07);
    a0_addr = 4'h2; expect_val(0, 8'h07, "R2 dir readback");
    expect_val(2, 8'h07, "R4 dir 07h gives oe 07h");
    wr0(4'h6, 8'h05);
    a0_addr = 4'h6; expect_val(0, 8'h05, "R2 dout readback");
    expect_val(1, 8'h05, "R3 mode 0 drives dout");
    a0_addr = 4'hA; expect_val(0, 8'h00, "R2 unmapped offset");
    // R10: strobe low
    @(negedge clk); a0_addr = 4'h2; a0_wd = 8'hFF; a0_wr = 1'b0;
    repeat (2) @(negedge clk);
    expect_val(0, 8'h07, "R10 no write without strobe");
    // R4: product terms
    pt0 = 8'hF0;
    expect_val(2, 8'hF7, "R4 oe is dir or pt");
    // R3: address-out mode
    ma0 = 8'h7E;
    wr0(4'h0, 8'h81);
    a0_addr = 4'h0; expect_val(0, 8'h81, "R2 mode readback");
    pins0(8'h81, 8'h07, 8'h00, 8'h05, "R3 address mode mux");
    ma0 = 8'h81;
    pins0(8'h81, 8'h07, 8'h00, 8'h05, "R3 address bits follow bus");
    // R5: open-drain on pins 0,1
    wr0(4'h4, 8'h03);
    pins0(8'h81, 8'h07, 8'h03, 8'h05, "R5 open drain");
    wr0(4'h6, 8'h02);
    pins0(8'h81, 8'h07, 8'h03, 8'h02, "R5 open drain release");
    // R6: slew select
    wr0(4'h4, 8'h30);
    expect_val(3, 8'h30, "R6 fast on push-pull pins");
    wr0(4'h4, 8'hFF);
    expect_val(3, 8'hF0, "R6 no fast on open-drain pins");
    pins0(8'h81, 8'h07, 8'hFF, 8'h02, "R5 R6 all drive bits");
    // R7: synchroniser latency
    @(negedge clk); pin0 = 8'hA5; a0_addr = 4'h8;
    expect_val(0, 8'h00, "R7 not yet visible");
    @(posedge clk); @(negedge clk);
    expect_val(0, 8'h00, "R7 one edge not enough");
    @(posedge clk); @(negedge clk);
    expect_val(0, 8'hA5, "R7 visible after two edges");
    // R8: no mode register on u1
    ma1 = 8'hFF;
    wr1(4'h0, 8'hFF);
    a1_addr = 4'h0; expect_val(4, 8'h00, "R8 mode reads zero");
    wr1(4'h6, 8'h02);
    expect_val(5, 8'h02, "R8 pins use dout");
    // R9: narrow instance
    wr1(4'h2, 8'hFF);
    a1_addr = 4'h2; expect_val(4, 8'h03, "R9 dir masked");
    pt1 = 8'hFF;
    expect_val(6, 8'h03, "R9 inactive pins ignore pt_oe");
    wr1(4'h6, 8'hFF);
    wr1(4'h4, 8'hFF);
    a1_addr = 4'h4; expect_val(4, 8'h03, "R9 drive masked");
    expect_val(7, 8'h02, "R9 R6 fast only pin 1");
    expect_val(5, 8'h02, "R9 R5 pin 0 released");
    expect_val(6, 8'h02, "R9 R5 pin 0 undriven");
    @(negedge clk); pin1 = 8'hFF; a1_addr = 4'h8;
    repeat (2) @(negedge clk);
    expect_val(4, 8'h03, "R9 R7 din masked");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule